// File: doc/BRIEF.md
# Semaphore Wait and Update Unit

This block holds a bank of counting semaphores that gate the issue of data-movement instructions and record their completion. Before an instruction is issued, its gating record presents a wait condition: a mode, a semaphore index and a threshold. The block raises a registered go signal once the indexed semaphore meets that condition. The same record names an update that the block applies when the instruction's read phase or full transfer finishes. The update can be an increment, an add of a value, or a direct write.

A separate completion port lets each descriptor post an 8-bit amount to its own completion semaphore. That semaphore is independent of the gating pair, but it lives in the same bank. A simple software port writes and reads any semaphore. Every change that lands on a semaphore in one cycle is merged into a single new value. Wait conditions are evaluated against the value after that cycle's changes.

Top module: `semgate_unit`

## Requirements
- R1: After reset every semaphore reads zero, `issue_go` is low and `sw_rdata` is zero.
- R2: A software write (`sw_wr`) loads `sw_wdata` into the addressed semaphore and wins over every hardware change to that semaphore in the same cycle. A software read (`sw_rd`) returns, one cycle later, the value the semaphore holds after that cycle's changes.
- R3: A completion post (`cmp_valid`) adds the zero-extended 8-bit `cmp_amount` to semaphore `cmp_idx`.
- R4: Update mode 0x03 adds one to semaphore `upd_idx` on a read-complete event (`evt_rd_done`). A full-complete event does not apply it.
- R5: Update mode 0x13 adds one, and mode 0x15 adds `upd_value`, on a full-complete event (`evt_full_done`). A read-complete event does not apply either mode.
- R6: Update mode 0x99 writes `upd_value` on a full-complete event and overrides same-cycle adds to that semaphore. Any other update mode changes nothing.
- R7: When an update add and a completion post hit the same semaphore in one cycle, both amounts are added.
- R8: Semaphore arithmetic wraps modulo 2^32.
- R9: Wait modes 0x01 (equal), 0x04 (strictly greater) and 0x05 (greater or equal) compare the semaphore, unsigned, against `issue_thresh_imm`. Modes 0x81, 0x84 and 0x85 make the same comparisons against `issue_thresh_reg`; bit 7 of the mode selects the register. Mode 0x00 grants unconditionally, and every other mode never grants.
- R10: `issue_go` rises in the cycle after `issue_req` when the condition holds on the semaphore value that includes that cycle's updates.
- R11: Once high, `issue_go` stays high while `issue_req` is held, even if the semaphore later changes. It is low in the cycle after `issue_req` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_req | input | 1 | Issue request holding a wait condition |
| issue_wait_mode | input | 8 | Wait mode code |
| issue_wait_idx | input | 8 | Semaphore examined by the wait |
| issue_thresh_imm | input | 32 | Immediate threshold |
| issue_thresh_reg | input | 32 | Register-sourced threshold |
| issue_go | output | 1 | Registered grant |
| upd_mode | input | 8 | Gating update mode code |
| upd_idx | input | 8 | Semaphore targeted by the gating update |
| upd_value | input | 32 | Add or write value for the update |
| evt_rd_done | input | 1 | Read phase completed (one-cycle pulse) |
| evt_full_done | input | 1 | Full transfer completed (one-cycle pulse) |
| cmp_valid | input | 1 | Completion post strobe |
| cmp_idx | input | 8 | Completion semaphore index |
| cmp_amount | input | 8 | Completion increment amount |
| sw_wr | input | 1 | Software write strobe |
| sw_rd | input | 1 | Software read strobe |
| sw_addr | input | 8 | Software semaphore index |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data, one cycle after `sw_rd` |

## Verification
The bench targets collisions in a single cycle, where a software write, a hardware write and two adds meet on one semaphore. A design that let the last writer win would drop an add, or would let a hardware change overwrite the software value. It checks that each update mode fires only on its own event: a design that did not key modes to events would count a read completion as a full completion. Threshold comparisons are probed at the boundary values, with one less, equal and one more than the semaphore, plus all-ones to catch signed comparison and confusion between strictly-greater and greater-or-equal. It also covers a wait satisfied by an update in the same cycle, which a design comparing stale values would grant one cycle late, and the hold of the grant after the semaphore moves away from the condition.

// File: rtl/semgate_pkg.sv
package semgate_pkg;

    // wait condition codes; bit 7 selects the register threshold
    localparam logic [7:0] WAIT_NONE    = 8'h00;
    localparam logic [6:0] WAIT_EQ      = 7'h01;
    localparam logic [6:0] WAIT_GT      = 7'h04;
    localparam logic [6:0] WAIT_GE      = 7'h05;
    localparam int         WAIT_REG_BIT = 7;

    // update codes, each tied to one completion event
    localparam logic [7:0] UPD_RD_INC   = 8'h03;
    localparam logic [7:0] UPD_FULL_INC = 8'h13;
    localparam logic [7:0] UPD_FULL_ADD = 8'h15;
    localparam logic [7:0] UPD_FULL_WR  = 8'h99;

    typedef enum logic [2:0] {
        CMP_NEVER,
        CMP_ALWAYS,
        CMP_EQ,
        CMP_GT,
        CMP_GE
    } cmp_kind_e;

endpackage

// File: rtl/semgate_wait_eval.sv
module semgate_wait_eval
    import semgate_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [7:0]   mode,
    input  logic [W-1:0] value,
    input  logic [W-1:0] thresh_imm,
    input  logic [W-1:0] thresh_reg,
    output logic         pass
);

    cmp_kind_e    kind;
    logic [W-1:0] thresh;

    always_comb begin
        thresh = mode[WAIT_REG_BIT] ? thresh_reg : thresh_imm;
        if (mode == WAIT_NONE) begin
            kind = CMP_ALWAYS;
        end else begin
            unique case (mode[6:0])
                WAIT_EQ: kind = CMP_EQ;
                WAIT_GT: kind = CMP_GT;
                WAIT_GE: kind = CMP_GE;
                default: kind = CMP_NEVER;
            endcase
        end
    end

    always_comb begin
        unique case (kind)
            CMP_ALWAYS: pass = 1'b1;
            CMP_EQ:     pass = (value == thresh);
            CMP_GT:     pass = (value >  thresh);
            CMP_GE:     pass = (value >= thresh);
            default:    pass = 1'b0;
        endcase
    end

endmodule

// File: rtl/semgate_upd_decode.sv
module semgate_upd_decode
    import semgate_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         evt_rd,
    input  logic         evt_full,
    input  logic [7:0]   mode,
    input  logic [W-1:0] value,
    output logic         add_en,
    output logic [W-1:0] add_amt,
    output logic         wr_en,
    output logic [W-1:0] wr_val
);

    always_comb begin
        add_en  = 1'b0;
        add_amt = '0;
        wr_en   = 1'b0;
        wr_val  = value;
        if (evt_rd && mode == UPD_RD_INC) begin
            add_en  = 1'b1;
            add_amt = W'(1);
        end
        if (evt_full) begin
            unique case (mode)
                UPD_FULL_INC: begin
                    add_en  = 1'b1;
                    add_amt = W'(1);
                end
                UPD_FULL_ADD: begin
                    add_en  = 1'b1;
                    add_amt = value;
                end
                UPD_FULL_WR: wr_en = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/semgate_bank.sv
module semgate_bank #(
    parameter int N  = 256,
    parameter int W  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_wr,
    input  logic [IW-1:0] sw_addr,
    input  logic [W-1:0]  sw_wdata,
    input  logic          hw_wr,
    input  logic [IW-1:0] hw_idx,
    input  logic [W-1:0]  hw_val,
    input  logic          a_en,
    input  logic [IW-1:0] a_idx,
    input  logic [W-1:0]  a_amt,
    input  logic          c_en,
    input  logic [IW-1:0] c_idx,
    input  logic [W-1:0]  c_amt,
    input  logic [IW-1:0] peek_a_idx,
    input  logic [IW-1:0] peek_b_idx,
    output logic [W-1:0]  peek_a,
    output logic [W-1:0]  peek_b
);

    typedef struct packed {
        logic [N-1:0][W-1:0] sem;
    } bank_st_t;

    bank_st_t     st_d, st_q;
    logic [W-1:0] nxt [N];

    for (genvar g = 0; g < N; g++) begin : g_entry
        logic         hit_a, hit_c;
        logic [W-1:0] inc;
        assign hit_a = a_en && (a_idx == IW'(g));
        assign hit_c = c_en && (c_idx == IW'(g));
        assign inc   = (hit_a ? a_amt : '0) + (hit_c ? c_amt : '0);
        assign nxt[g] = (sw_wr && sw_addr == IW'(g)) ? sw_wdata :
                        (hw_wr && hw_idx  == IW'(g)) ? hw_val   :
                        st_q.sem[g] + inc;
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            st_d.sem[i] = nxt[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign peek_a = nxt[peek_a_idx];
    assign peek_b = nxt[peek_b_idx];

    p_sw_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> st_q.sem[$past(sw_addr)] == $past(sw_wdata));

    p_cmp_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
        c_en && !sw_wr && !hw_wr && !a_en
        |=> st_q.sem[$past(c_idx)] == $past(st_q.sem[c_idx]) + $past(c_amt));

    p_hw_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hw_wr && !(sw_wr && sw_addr == hw_idx)
        |=> st_q.sem[$past(hw_idx)] == $past(hw_val));

    p_sum_adds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        a_en && c_en && a_idx == c_idx && !sw_wr && !hw_wr
        |=> st_q.sem[$past(a_idx)] == $past(st_q.sem[a_idx]) + $past(a_amt) + $past(c_amt));

endmodule

// File: rtl/semgate_unit.sv
module semgate_unit #(
    parameter int N  = 256,
    parameter int W  = 32,
    parameter int IW = $clog2(N),
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_req,
    input  logic [7:0]    issue_wait_mode,
    input  logic [IW-1:0] issue_wait_idx,
    input  logic [W-1:0]  issue_thresh_imm,
    input  logic [W-1:0]  issue_thresh_reg,
    output logic          issue_go,
    input  logic [7:0]    upd_mode,
    input  logic [IW-1:0] upd_idx,
    input  logic [W-1:0]  upd_value,
    input  logic          evt_rd_done,
    input  logic          evt_full_done,
    input  logic          cmp_valid,
    input  logic [IW-1:0] cmp_idx,
    input  logic [AW-1:0] cmp_amount,
    input  logic          sw_wr,
    input  logic          sw_rd,
    input  logic [IW-1:0] sw_addr,
    input  logic [W-1:0]  sw_wdata,
    output logic [W-1:0]  sw_rdata
);

    typedef struct packed {
        logic         go;
        logic [W-1:0] rdata;
    } ctl_st_t;

    ctl_st_t      st_d, st_q;
    logic         u_add_en, u_wr_en, cond_ok;
    logic [W-1:0] u_add_amt, u_wr_val, wait_val, sw_val;

    semgate_upd_decode #(.W(W)) i_decode (
        .evt_rd   (evt_rd_done),
        .evt_full (evt_full_done),
        .mode     (upd_mode),
        .value    (upd_value),
        .add_en   (u_add_en),
        .add_amt  (u_add_amt),
        .wr_en    (u_wr_en),
        .wr_val   (u_wr_val)
    );

    semgate_bank #(.N(N), .W(W), .IW(IW)) i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_wr      (sw_wr),
        .sw_addr    (sw_addr),
        .sw_wdata   (sw_wdata),
        .hw_wr      (u_wr_en),
        .hw_idx     (upd_idx),
        .hw_val     (u_wr_val),
        .a_en       (u_add_en),
        .a_idx      (upd_idx),
        .a_amt      (u_add_amt),
        .c_en       (cmp_valid),
        .c_idx      (cmp_idx),
        .c_amt      (W'(cmp_amount)),
        .peek_a_idx (issue_wait_idx),
        .peek_b_idx (sw_addr),
        .peek_a     (wait_val),
        .peek_b     (sw_val)
    );

    semgate_wait_eval #(.W(W)) i_wait (
        .mode       (issue_wait_mode),
        .value      (wait_val),
        .thresh_imm (issue_thresh_imm),
        .thresh_reg (issue_thresh_reg),
        .pass       (cond_ok)
    );

    always_comb begin
        st_d       = st_q;
        st_d.go    = issue_req && (st_q.go || cond_ok);
        if (sw_rd) st_d.rdata = sw_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign issue_go = st_q.go;
    assign sw_rdata = st_q.rdata;

    p_go_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_req |=> !issue_go);

    p_go_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        issue_go && issue_req |=> issue_go);

    p_nowait_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_req && issue_wait_mode == 8'h00 |=> issue_go);

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rd |=> $stable(sw_rdata));

endmodule

// File: tb/test_semgate_unit.sv
module test_semgate_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_req = 1'b0;
    logic [7:0]  issue_wait_mode = '0;
    logic [7:0]  issue_wait_idx = '0;
    logic [31:0] issue_thresh_imm = '0;
    logic [31:0] issue_thresh_reg = '0;
    logic        issue_go;
    logic [7:0]  upd_mode = '0;
    logic [7:0]  upd_idx = '0;
    logic [31:0] upd_value = '0;
    logic        evt_rd_done = 1'b0;
    logic        evt_full_done = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [7:0]  cmp_idx = '0;
    logic [7:0]  cmp_amount = '0;
    logic        sw_wr = 1'b0;
    logic        sw_rd = 1'b0;
    logic [7:0]  sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    semgate_unit i_semgate_unit (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic sw_write(input logic [7:0] idx, input logic [31:0] val);
        @(negedge clk);
        sw_wr = 1'b1; sw_addr = idx; sw_wdata = val;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic sw_read_chk(input logic [7:0] idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        sw_rd = 1'b1; sw_addr = idx;
        @(negedge clk);
        sw_rd = 1'b0;
        chk(tag, sw_rdata, exp);
    endtask

    task automatic post(input logic [7:0] idx, input logic [7:0] amt);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_idx = idx; cmp_amount = amt;
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic gate_upd(input logic [7:0] mode, input logic [7:0] idx,
                            input logic [31:0] val, input bit rd, input bit full);
        @(negedge clk);
        upd_mode = mode; upd_idx = idx; upd_value = val;
        evt_rd_done = rd; evt_full_done = full;
        @(negedge clk);
        evt_rd_done = 1'b0; evt_full_done = 1'b0;
    endtask

    task automatic wait_chk(input logic [7:0] mode, input logic [7:0] idx,
                            input logic [31:0] imm, input logic [31:0] rth,
                            input bit exp, input string tag);
        @(negedge clk);
        issue_req = 1'b1; issue_wait_mode = mode; issue_wait_idx = idx;
        issue_thresh_imm = imm; issue_thresh_reg = rth;
        @(negedge clk);
        chk(tag, 32'(issue_go), 32'(exp));
        issue_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 go after reset", 32'(issue_go), 32'd0);
        chk("R1 rdata after reset", sw_rdata, 32'd0);
        sw_read_chk(8'd0, 32'd0, "R1 sem0 reset");
        sw_read_chk(8'd255, 32'd0, "R1 sem255 reset");
    endtask

    task automatic t_sw();
        sw_write(8'd3, 32'h1234_5678);
        sw_read_chk(8'd3, 32'h1234_5678, "R2 sw write/read");
        sw_write(8'd7, 32'd100);
        @(negedge clk);
        sw_wr = 1'b1; sw_addr = 8'd7; sw_wdata = 32'd40;
        cmp_valid = 1'b1; cmp_idx = 8'd7; cmp_amount = 8'd5;
        upd_mode = 8'h15; upd_idx = 8'd7; upd_value = 32'd9; evt_full_done = 1'b1;
        @(negedge clk);
        sw_wr = 1'b0; cmp_valid = 1'b0; evt_full_done = 1'b0;
        sw_read_chk(8'd7, 32'd40, "R2 sw write beats hw adds");
        // read in the same cycle as an add returns the updated value
        @(negedge clk);
        sw_rd = 1'b1; sw_addr = 8'd7; cmp_valid = 1'b1; cmp_idx = 8'd7; cmp_amount = 8'd2;
        @(negedge clk);
        sw_rd = 1'b0; cmp_valid = 1'b0;
        chk("R2 read sees same-cycle update", sw_rdata, 32'd42);
    endtask

    task automatic t_cmp();
        sw_write(8'd5, 32'd10);
        post(8'd5, 8'd7);
        sw_read_chk(8'd5, 32'd17, "R3 completion add");
        post(8'd5, 8'd255);
        sw_read_chk(8'd5, 32'd272, "R3 completion add 255 zero-extended");
    endtask

    task automatic t_rd_upd();
        sw_write(8'd9, 32'd20);
        gate_upd(8'h03, 8'd9, 32'd50, 1'b1, 1'b0);
        sw_read_chk(8'd9, 32'd21, "R4 read-done increment");
        gate_upd(8'h03, 8'd9, 32'd50, 1'b0, 1'b1);
        sw_read_chk(8'd9, 32'd21, "R4 mode 0x03 ignored on full-done");
    endtask

    task automatic t_full();
        gate_upd(8'h13, 8'd9, 32'd50, 1'b0, 1'b1);
        sw_read_chk(8'd9, 32'd22, "R5 full-done increment");
        gate_upd(8'h15, 8'd9, 32'd100, 1'b0, 1'b1);
        sw_read_chk(8'd9, 32'd122, "R5 full-done add value");
        gate_upd(8'h15, 8'd9, 32'd100, 1'b1, 1'b0);
        gate_upd(8'h13, 8'd9, 32'd100, 1'b1, 1'b0);
        sw_read_chk(8'd9, 32'd122, "R5 full modes ignored on read-done");
    endtask

    task automatic t_write();
        sw_write(8'd10, 32'd1);
        @(negedge clk);
        upd_mode = 8'h99; upd_idx = 8'd10; upd_value = 32'h0000_0ABC; evt_full_done = 1'b1;
        cmp_valid = 1'b1; cmp_idx = 8'd10; cmp_amount = 8'd3;
        @(negedge clk);
        evt_full_done = 1'b0; cmp_valid = 1'b0;
        sw_read_chk(8'd10, 32'h0000_0ABC, "R6 hw write overrides add");
        gate_upd(8'h42, 8'd10, 32'd7, 1'b1, 1'b1);
        sw_read_chk(8'd10, 32'h0000_0ABC, "R6 unknown update mode ignored");
    endtask

    task automatic t_sum();
        sw_write(8'd11, 32'd0);
        @(negedge clk);
        upd_mode = 8'h15; upd_idx = 8'd11; upd_value = 32'd1000; evt_full_done = 1'b1;
        cmp_valid = 1'b1; cmp_idx = 8'd11; cmp_amount = 8'd5;
        @(negedge clk);
        evt_full_done = 1'b0; cmp_valid = 1'b0;
        sw_read_chk(8'd11, 32'd1005, "R7 same-cycle adds summed");
        @(negedge clk);
        upd_mode = 8'h03; upd_idx = 8'd11; evt_rd_done = 1'b1;
        cmp_valid = 1'b1; cmp_idx = 8'd12; cmp_amount = 8'd4;
        @(negedge clk);
        evt_rd_done = 1'b0; cmp_valid = 1'b0;
        sw_read_chk(8'd11, 32'd1006, "R7 distinct targets, gate side");
        sw_read_chk(8'd12, 32'd4, "R7 distinct targets, completion side");
    endtask

    task automatic t_wrap();
        sw_write(8'd12, 32'hFFFF_FFFF);
        post(8'd12, 8'd2);
        sw_read_chk(8'd12, 32'd1, "R8 wrap on completion add");
        gate_upd(8'h15, 8'd12, 32'hFFFF_FFF0, 1'b0, 1'b1);
        sw_read_chk(8'd12, 32'hFFFF_FFF1, "R8 add large value");
        gate_upd(8'h15, 8'd12, 32'h0000_0010, 1'b0, 1'b1);
        sw_read_chk(8'd12, 32'd1, "R8 wrap on gating add");
    endtask

    task automatic t_wait();
        sw_write(8'd20, 32'd5);
        wait_chk(8'h01, 8'd20, 32'd5, 32'd0, 1'b1, "R9 EQ match");
        wait_chk(8'h01, 8'd20, 32'd6, 32'd5, 1'b0, "R9 EQ mismatch");
        wait_chk(8'h04, 8'd20, 32'd5, 32'd0, 1'b0, "R9 GT equal value");
        wait_chk(8'h04, 8'd20, 32'd4, 32'd9, 1'b1, "R9 GT below");
        wait_chk(8'h05, 8'd20, 32'd5, 32'd9, 1'b1, "R9 GE equal");
        wait_chk(8'h05, 8'd20, 32'd6, 32'd0, 1'b0, "R9 GE above");
        wait_chk(8'h04, 8'd20, 32'hFFFF_FFFF, 32'd0, 1'b0, "R9 GT unsigned");
        wait_chk(8'h85, 8'd20, 32'd0, 32'd6, 1'b0, "R9 reg GE above");
        wait_chk(8'h85, 8'd20, 32'd9, 32'd5, 1'b1, "R9 reg GE equal");
        wait_chk(8'h81, 8'd20, 32'd5, 32'd4, 1'b0, "R9 reg EQ uses reg");
        wait_chk(8'h84, 8'd20, 32'd9, 32'd4, 1'b1, "R9 reg GT");
        wait_chk(8'h00, 8'd20, 32'd99, 32'd99, 1'b1, "R9 no-wait grant");
        wait_chk(8'h02, 8'd20, 32'd5, 32'd5, 1'b0, "R9 unknown mode");
    endtask

    task automatic t_post_update();
        sw_write(8'd21, 32'd4);
        @(negedge clk);
        issue_req = 1'b1; issue_wait_mode = 8'h01; issue_wait_idx = 8'd21;
        issue_thresh_imm = 32'd5;
        cmp_valid = 1'b1; cmp_idx = 8'd21; cmp_amount = 8'd1;
        @(negedge clk);
        cmp_valid = 1'b0;
        chk("R10 wait sees same-cycle update", 32'(issue_go), 32'd1);
        issue_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_hold();
        sw_write(8'd22, 32'd5);
        @(negedge clk);
        issue_req = 1'b1; issue_wait_mode = 8'h01; issue_wait_idx = 8'd22;
        issue_thresh_imm = 32'd5;
        @(negedge clk);
        chk("R11 go rises", 32'(issue_go), 32'd1);
        cmp_valid = 1'b1; cmp_idx = 8'd22; cmp_amount = 8'd1;
        @(negedge clk);
        cmp_valid = 1'b0;
        @(negedge clk);
        chk("R11 go held after condition lost", 32'(issue_go), 32'd1);
        issue_req = 1'b0;
        @(negedge clk);
        chk("R11 go drops with request", 32'(issue_go), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sw();
        t_cmp();
        t_rd_upd();
        t_full();
        t_write();
        t_sum();
        t_wrap();
        t_wait();
        t_post_update();
        t_hold();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
            $finish;
        end
    end

endmodule